// File: doc/BRIEF.md
# Sensorless Spindle Commutation Sequencer

This block holds the commutation step of a three-phase brushless spindle motor that has no Hall sensors, and turns that step into per-phase drive enables. Control bits from a processor-written register choose how the step advances. In search mode the processor moves the motor like a stepper: every level change of a step bit advances one step. In run mode the step advances on digital zero-crossing pulses from an external back-EMF comparator. Each pulse is first screened by a blanking window that opens after every commutation. The pulse then waits out a delay, set by a 4-bit code as a fraction of the last measured commutation period.

All timing comes from the system clock. The drive decode gives each phase a high-side enable, a low-side enable and a floating indication. It supports bipolar drive, with one phase sourcing, one sinking and one floating, and unipolar drive, with a single sinking phase against the motor centre tap. When the spindle enable is low, all low sides are switched on to brake the motor dynamically. A synthesised Hall signal toggles once per electrical half-cycle in run mode, so its frequency tracks the spindle speed.

Top module: `spin_commutator`

## Requirements
- R1: While `spin_en` is 0, `hs_on` is 000, `ls_on` is 111, `ph_float` is 000 and `brake` is 1, whatever the step. While `spin_en` is 1, `brake` is 0.
- R2: A synchronous reset or `seq_rel_n` = 0 forces `comm_state` to 0 at the next clock edge. While `seq_rel_n` is 0 the step does not advance.
- R3: In search mode (`run_sel` = 0), each clock edge that sees `step_tog` differ from its value at the previous edge advances `comm_state` by one. The step counts 0,1,2,3,4,5 and wraps to 0. The new value is visible after that edge, so both rising and falling toggles count.
- R4: In run mode, an accepted zero-cross pulse sampled at edge z causes a commutation at edge z+1+D. D = floor(P*dly_code/16), where P is the number of clock cycles between the two most recent commutations (saturating at 2^PER_W-1).
- R5: A zero-cross pulse sampled at the commutation edge a, or at any of the next MASK_CYC edges (a+1 to a+MASK_CYC), is ignored. A pulse sampled at edge a+MASK_CYC+1 is accepted.
- R6: In bipolar drive (`uni_sel` = 0, `spin_en` = 1), step s turns on the high side of phase s>>1 and the low side of phase ((s+1)>>1 + 1) mod 3. Phase 0 is bit 0 and phase 2 is bit 2. The third phase has its `ph_float` bit set.
- R7: In unipolar drive (`uni_sel` = 1, `spin_en` = 1), `hs_on` is 000. Only the low side of phase ((s+1)>>1 + 1) mod 3 is on, and the other two phases float.
- R8: `hall_syn` is 1 in run mode for steps 0, 1 and 2, and 0 for steps 3, 4 and 5. In search mode it is 0.
- R9: `step_tog` changes have no effect in run mode, and zero-cross pulses have no effect in search mode.
- R10: At most one high-side enable is on, and no phase has its high and low side on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timing derives from it |
| rst_n | input | 1 | Synchronous active-low reset |
| spin_en | input | 1 | 1 enables drive; 0 applies dynamic brake |
| seq_rel_n | input | 1 | 0 holds the step at 0 |
| run_sel | input | 1 | 1 selects run mode, 0 selects search mode |
| step_tog | input | 1 | Processor step bit; each level change steps in search mode |
| uni_sel | input | 1 | 1 selects unipolar drive, 0 bipolar |
| zc_evt | input | 1 | Zero-crossing pulse from the back-EMF comparator |
| dly_code | input | DLY_W (4) | Phase delay in sixteenths of the last period |
| hs_on | output | 3 | High-side enable per phase |
| ls_on | output | 3 | Low-side enable per phase |
| ph_float | output | 3 | Phase left undriven, for back-EMF sensing |
| brake | output | 1 | Dynamic brake active |
| hall_syn | output | 1 | Synthesised Hall signal |
| comm_state | output | 3 | Current commutation step, 0 to 5 |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any check applies. They also assume that `step_tog` is 0 when reset is released, so that no step occurs at the release. The stimulus drives every input at the falling clock edge, keeps `step_tog` at 0 through reset, and ends each zero-cross pulse after one clock edge. Gaps between zero-cross pulses are chosen to exceed the blanking window unless the test is probing that window. This keeps each pulse unambiguous when the bench computes the expected delay.

// File: rtl/spin_seq_pkg.sv
// Package: shared constants, step type and step/phase arithmetic for the
// spindle commutation sequencer. Assumes a three-phase motor, six steps.
package spin_seq_pkg;
    localparam int NUM_PH = 3;
    localparam int NUM_ST = 6;

    typedef logic [2:0] cstate_t;

    // Next step in the 0..5 ring.
    function automatic cstate_t st_next(cstate_t s);
        return (s == cstate_t'(NUM_ST - 1)) ? cstate_t'(0) : s + cstate_t'(1);
    endfunction

    // Phase sourcing current in bipolar drive.
    function automatic logic [1:0] src_phase(cstate_t s);
        return s[2:1];
    endfunction

    // Phase sinking current in either drive mode.
    function automatic logic [1:0] sink_phase(cstate_t s);
        case (s)
            3'd0:    return 2'd1;
            3'd1:    return 2'd2;
            3'd2:    return 2'd2;
            3'd3:    return 2'd0;
            3'd4:    return 2'd0;
            3'd5:    return 2'd1;
            default: return 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/spin_step_src.sv
// Search-mode step source: flags a step whenever the processor step bit
// differs from its value at the previous edge. Assumes step_tog is 0 at
// reset release.
module spin_step_src (
    input  logic clk,
    input  logic rst_n,
    input  logic run_sel,
    input  logic step_tog,
    output logic step_req
);
    logic tog_q;

    // Track the step bit every cycle so a mode change never leaves a stale edge.
    always_ff @(posedge clk) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= step_tog;
    end

    assign step_req = !run_sel && (step_tog != tog_q);
endmodule

// File: rtl/spin_zc_timer.sv
// Commutation timing: measures the period between commutations, blanks
// zero-cross pulses after each commutation, delays an accepted pulse by a
// fraction of the last period, and merges the search-mode step request.
// Assumes zc_evt is synchronous to clk.
module spin_zc_timer #(
    parameter int PER_W    = 12,
    parameter int MASK_CYC = 6,
    parameter int DLY_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_n,
    input  logic             run_sel,
    input  logic             zc_evt,
    input  logic [DLY_W-1:0] dly_code,
    input  logic             step_req,
    output logic             adv
);
    localparam int MASK_W = $clog2(MASK_CYC + 1);
    localparam int PROD_W = PER_W + DLY_W;

    logic [PER_W-1:0]  since_q, per_q, wait_q;
    logic [MASK_W-1:0] mask_q;
    logic              pend_q;
    logic [PROD_W-1:0] prod;
    logic [PER_W-1:0]  dly_cyc;
    logic              fire, zc_ok;

    assign prod    = PROD_W'(per_q) * PROD_W'(dly_code);
    assign dly_cyc = prod[PROD_W-1:DLY_W];
    assign fire    = pend_q && (wait_q == '0);
    assign zc_ok   = run_sel && zc_evt && !pend_q && (mask_q == '0);
    assign adv     = hold_n && (run_sel ? fire : step_req);

    // Period measurement: cycles since the last commutation, latched at each one.
    always_ff @(posedge clk) begin
        if (!rst_n || !hold_n) begin
            since_q <= '0;
            per_q   <= '0;
        end else if (adv) begin
            per_q   <= since_q;
            since_q <= PER_W'(1);
        end else if (since_q != '1) begin
            since_q <= since_q + PER_W'(1);
        end
    end

    // Blanking window reloaded on every commutation.
    always_ff @(posedge clk) begin
        if (!rst_n || !hold_n)  mask_q <= '0;
        else if (adv)           mask_q <= MASK_W'(MASK_CYC);
        else if (mask_q != '0)  mask_q <= mask_q - MASK_W'(1);
    end

    // Pending commutation: load the scaled delay on an accepted pulse, count down.
    always_ff @(posedge clk) begin
        if (!rst_n || !hold_n || !run_sel) begin
            pend_q <= 1'b0;
            wait_q <= '0;
        end else if (fire) begin
            pend_q <= 1'b0;
        end else if (zc_ok) begin
            pend_q <= 1'b1;
            wait_q <= dly_cyc;
        end else if (pend_q) begin
            wait_q <= wait_q - PER_W'(1);
        end
    end

    // R5: no commutation can be pending while the blanking window is open.
    a_r5_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q != '0) |-> !pend_q);
    // R9: search mode never leaves a zero-cross commutation pending.
    a_r9_search_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
        !run_sel |=> !pend_q);
endmodule

// File: rtl/spin_phase_map.sv
// Drive decode: maps the step to per-phase high/low enables and floating
// flags for bipolar or unipolar drive, applies dynamic brake when disabled,
// and forms the synthesised Hall signal. Purely combinational; clk and
// rst_n only time the assertions.
module spin_phase_map
    import spin_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cstate_t           state,
    input  logic              spin_en,
    input  logic              uni_sel,
    input  logic              run_sel,
    output logic [NUM_PH-1:0] hs_on,
    output logic [NUM_PH-1:0] ls_on,
    output logic [NUM_PH-1:0] ph_float,
    output logic              brake,
    output logic              hall_syn
);
    for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
        logic src_hit, sink_hit;
        assign src_hit     = (src_phase(state) == 2'(p));
        assign sink_hit    = (sink_phase(state) == 2'(p));
        assign hs_on[p]    = spin_en && !uni_sel && src_hit;
        assign ls_on[p]    = !spin_en || sink_hit;
        assign ph_float[p] = spin_en && !hs_on[p] && !ls_on[p];
    end

    assign brake    = !spin_en;
    assign hall_syn = run_sel && (state < 3'd3);

    // R10: never more than one sourcing phase.
    a_r10_single_source: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hs_on));
    // R10: no shoot-through on any half bridge.
    a_r10_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_on & ls_on) == '0);
    // R1: disabled drive means all low sides on, nothing floating.
    a_r1_brake_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !spin_en |-> (ls_on == '1) && (hs_on == '0) && (ph_float == '0));
endmodule

// File: rtl/spin_commutator.sv
// Top: sensorless spindle commutation sequencer. Holds the six-step
// commutation state, advanced by processor toggles (search) or delayed,
// blanked zero-cross pulses (run), and decodes it to phase drive enables.
// Assumes all inputs are synchronous to clk.
module spin_commutator
    import spin_seq_pkg::*;
#(
    parameter int PER_W    = 12,
    parameter int MASK_CYC = 6,
    parameter int DLY_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spin_en,
    input  logic             seq_rel_n,
    input  logic             run_sel,
    input  logic             step_tog,
    input  logic             uni_sel,
    input  logic             zc_evt,
    input  logic [DLY_W-1:0] dly_code,
    output logic [2:0]       hs_on,
    output logic [2:0]       ls_on,
    output logic [2:0]       ph_float,
    output logic             brake,
    output logic             hall_syn,
    output logic [2:0]       comm_state
);
    cstate_t state_q;
    logic    step_req, adv;

    spin_step_src u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_sel  (run_sel),
        .step_tog (step_tog),
        .step_req (step_req)
    );

    spin_zc_timer #(
        .PER_W    (PER_W),
        .MASK_CYC (MASK_CYC),
        .DLY_W    (DLY_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_n   (seq_rel_n),
        .run_sel  (run_sel),
        .zc_evt   (zc_evt),
        .dly_code (dly_code),
        .step_req (step_req),
        .adv      (adv)
    );

    // Commutation step register: cleared by reset or hold, advanced on adv.
    always_ff @(posedge clk) begin
        if (!rst_n || !seq_rel_n) state_q <= '0;
        else if (adv)             state_q <= st_next(state_q);
    end

    spin_phase_map u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state_q),
        .spin_en  (spin_en),
        .uni_sel  (uni_sel),
        .run_sel  (run_sel),
        .hs_on    (hs_on),
        .ls_on    (ls_on),
        .ph_float (ph_float),
        .brake    (brake),
        .hall_syn (hall_syn)
    );

    assign comm_state = state_q;

    // R2: hold forces step 0 on the next edge.
    a_r2_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_rel_n |=> comm_state == 3'd0);
    // R3: outside hold the step either stays or moves one along the ring.
    a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        seq_rel_n |=> (comm_state == $past(comm_state)) ||
                      (comm_state == st_next($past(comm_state))));
    // R3: the step stays within 0..5.
    a_r3_state_range: assert property (@(posedge clk) disable iff (!rst_n)
        comm_state < 3'd6);
endmodule

// File: tb/sim_spin_commutator.sv
`timescale 1ns/1ps
module sim_spin_commutator;
    localparam int MASK = 6;

    logic       clk = 1'b0;
    logic       rst_n, spin_en, seq_rel_n, run_sel, step_tog, uni_sel, zc_evt;
    logic [3:0] dly_code;
    logic [2:0] hs_on, ls_on, ph_float, comm_state;
    logic       brake, hall_syn;
    int         n_chk = 0, n_err = 0, exp_st = 0;

    always #2.5 clk = ~clk;

    spin_commutator #(.PER_W(12), .MASK_CYC(MASK), .DLY_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .spin_en(spin_en), .seq_rel_n(seq_rel_n),
        .run_sel(run_sel), .step_tog(step_tog), .uni_sel(uni_sel),
        .zc_evt(zc_evt), .dly_code(dly_code), .hs_on(hs_on), .ls_on(ls_on),
        .ph_float(ph_float), .brake(brake), .hall_syn(hall_syn),
        .comm_state(comm_state)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected drive from the decode rules in R1, R6 and R7.
    task automatic chk_drive(string req);
        int s, hi, lo, ehs, els, efl;
        s  = int'(comm_state);
        hi = s / 2;
        lo = ((s + 1) / 2 + 1) % 3;
        if (!spin_en) begin
            ehs = 0; els = 7; efl = 0;
        end else if (uni_sel) begin
            ehs = 0; els = 1 << lo; efl = 7 & ~els;
        end else begin
            ehs = 1 << hi; els = 1 << lo; efl = 7 & ~(ehs | els);
        end
        chk(req, int'(hs_on), ehs);
        chk(req, int'(ls_on), els);
        chk(req, int'(ph_float), efl);
        chk(req, int'(brake), spin_en ? 0 : 1);
    endtask

    task automatic toggle_step();
        step_tog = ~step_tog;
        @(negedge clk);
    endtask

    // Pulse zc for one edge; count edges after it until the step moves.
    task automatic zc_meas(string req, int exp_n);
        int n;
        logic [2:0] old;
        old = comm_state;
        zc_evt = 1'b1;
        @(posedge clk);
        @(negedge clk);
        zc_evt = 1'b0;
        n = 0;
        while (comm_state == old && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(req, n, exp_n);
        exp_st = (exp_st + 1) % 6;
        chk(req, int'(comm_state), exp_st);
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_up();
    end

    initial begin
        rst_n = 0; spin_en = 0; seq_rel_n = 1; run_sel = 0; step_tog = 0;
        uni_sel = 0; zc_evt = 0; dly_code = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // Reset state: step 0, brake applied, no Hall in search mode.
        chk("R2", int'(comm_state), 0);
        chk_drive("R1");
        chk("R8", int'(hall_syn), 0);

        spin_en = 1;
        @(negedge clk);
        // R3/R6: toggle sweep over two full rings in bipolar drive.
        for (int i = 0; i < 13; i++) begin
            toggle_step();
            exp_st = (exp_st + 1) % 6;
            chk("R3", int'(comm_state), exp_st);
            chk_drive("R6");
            chk("R8", int'(hall_syn), 0);
        end
        // R7: unipolar decode over every step.
        uni_sel = 1;
        for (int i = 0; i < 6; i++) begin
            toggle_step();
            exp_st = (exp_st + 1) % 6;
            chk("R3", int'(comm_state), exp_st);
            chk_drive("R7");
        end
        uni_sel = 0;
        // R1: brake in several steps.
        spin_en = 0;
        for (int i = 0; i < 3; i++) begin
            toggle_step();
            exp_st = (exp_st + 1) % 6;
            chk_drive("R1");
        end
        spin_en = 1;
        @(negedge clk);
        // R2: hold clears the step and blocks toggles.
        seq_rel_n = 0;
        @(negedge clk);
        chk("R2", int'(comm_state), 0);
        for (int i = 0; i < 3; i++) begin
            toggle_step();
            chk("R2", int'(comm_state), 0);
        end
        seq_rel_n = 1;
        exp_st = 0;
        @(negedge clk);
        toggle_step();
        exp_st = 1;
        chk("R2", int'(comm_state), 1);
        // R9: zero-cross pulse ignored in search mode.
        zc_evt = 1;
        @(negedge clk);
        zc_evt = 0;
        repeat (5) @(negedge clk);
        chk("R9", int'(comm_state), exp_st);

        // Run mode.
        run_sel = 1; dly_code = 0;
        repeat (10) @(negedge clk);
        chk("R8", int'(hall_syn), exp_st < 3 ? 1 : 0);
        // R9: step toggles ignored in run mode.
        toggle_step();
        repeat (5) @(negedge clk);
        chk("R9", int'(comm_state), exp_st);
        // R8: Hall over a full ring of zero-cross commutations.
        for (int i = 0; i < 7; i++) begin
            zc_meas("R4", 1);
            chk("R8", int'(hall_syn), exp_st < 3 ? 1 : 0);
            chk_drive("R6");
            repeat (10) @(negedge clk);
        end
        // R4: delay sweep, every code at two periods.
        for (int g = 0; g < 2; g++) begin
            int per;
            per = (g == 0) ? 40 : 100;
            for (int d = 0; d < 16; d++) begin
                dly_code = 0;
                zc_meas("R4", 1);
                repeat (per - 2) @(negedge clk);
                zc_meas("R4", 1);
                dly_code = 4'(d);
                repeat (20) @(negedge clk);
                zc_meas("R4", 1 + ((per * d) >> 4));
                repeat (10) @(negedge clk);
            end
        end
        // R5: pulses held across the whole blanking window are ignored.
        dly_code = 0;
        zc_meas("R4", 1);
        zc_evt = 1;
        repeat (MASK) @(negedge clk);
        zc_evt = 0;
        repeat (10) @(negedge clk);
        chk("R5", int'(comm_state), exp_st);
        // R5: single pulse at the last blanked edge is ignored.
        zc_meas("R4", 1);
        repeat (MASK - 1) @(negedge clk);
        zc_evt = 1;
        @(negedge clk);
        zc_evt = 0;
        repeat (10) @(negedge clk);
        chk("R5", int'(comm_state), exp_st);
        // R5: first edge after the window is accepted.
        zc_meas("R4", 1);
        repeat (MASK) @(negedge clk);
        zc_meas("R5", 1);
        finish_up();
    end
endmodule